// File: doc/BRIEF.md
# Half-band decimate-by-two filter

This block is the second stage of a sigma-delta ADC decimation chain. An upstream CIC decimator (rate change 64) delivers signed 16-bit words at 28 kHz. This stage halves that rate to 14 kHz, so the chain decimates by 128 in total. The low-pass is a 7-tap symmetric half-band FIR with coefficients (-1, 0, 9, 16, 9, 0, -1)/32. Its passband reaches about 2.5 kHz at the input rate, and its gain at DC is exactly one.

No general multiplier is used. The two zero taps are never computed. Each symmetric pair of delayed samples is summed first, so each coefficient is applied once. Each nonzero coefficient is a canonical-signed-digit set of shifts and adds: 9/32 = 2^-2 + 2^-5, -1/32 = -2^-5, and the centre 1/2 is a single shift. The sum is formed with three guard bits. It is then rounded half-up back to 16 bits and saturated.

Both the input and the output are valid-qualified streams on one clock with a synchronous active-high reset. The filter works out an output only on every second accepted input. The result is registered, so it appears the cycle after that input strobe.

Top module: `hbdec2_filter`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_valid` is 0 and `out_data` is 0. Reset also empties the delay line and restarts the input count.
- R2: Counting accepted inputs (`in_valid` high at a rising edge) from 1 after reset, `out_valid` is high for exactly one cycle, in the cycle after input 7, 9, 11 and so on (every odd count from 7 up). It is low in every other cycle.
- R3: With x[0] the input just accepted and x[k] the input accepted k strobes earlier, the output is sat16(floor((-(x[0]+x[6]) + 9*(x[2]+x[4]) + 16*x[3] + 16) / 32)). x[1] and x[5] have no effect.
- R4: A constant input c, held for at least 7 inputs, gives the output c (unity DC gain).
- R5: An input that alternates between +A and -A on every sample gives the output 0 once 7 such inputs have filled the window.
- R6: Results above 32767 are output as 32767, and results below -32768 are output as -32768.
- R7: Rounding is half-up. A lone +1 sample seen at the centre tap gives 1, and a lone -1 sample seen at the centre tap gives 0.
- R8: Cycles with `in_valid` low do not move the delay line. `out_data` holds its last value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | One-cycle pulse marking a new output word |
| out_data | output | 16 | Filtered, decimated sample, two's complement |

## Verification
The assertions check the output timing on every cycle:
- `out_valid` never lasts more than one cycle.
- It always follows an input strobe.
- It only comes after an odd input count of at least seven.
- `out_data` never moves between pulses.

The output values can only be shown by the bench's scenarios, which compare against a behavioural reference model. These cover:
- the coefficient arithmetic under an impulse and under a stream with idle gaps;
- unity DC gain;
- the null at the Nyquist rate;
- half-up rounding at the centre tap;
- saturation in both directions;
- the restart after a reset in mid-stream.

// File: rtl/hbdec2_pkg.sv
package hbdec2_pkg;

    localparam int DATA_W  = 16;                       // sample width
    localparam int FRAC_SH = 5;                        // coefficient denominator 2^FRAC_SH
    localparam int GUARD_W = 3;                        // headroom bits in the sum
    localparam int N_TAPS  = 7;                        // filter length
    localparam int HIST_D  = N_TAPS - 1;               // stored past samples
    localparam int ACC_W   = DATA_W + FRAC_SH + GUARD_W;
    localparam int FILL_W  = $clog2(N_TAPS);

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    // Input phase within a decimation pair
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    // Pre-added symmetric operands
    typedef struct packed {
        acc_t outer;    // ends of the window, weight -1/32
        acc_t inner;    // second ring, weight 9/32
        acc_t center;   // middle sample, weight 1/2
    } pairsum_t;

    localparam acc_t HALF_LSB = acc_t'(2 ** (FRAC_SH - 1));
    localparam acc_t SAT_HI   = acc_t'((2 ** (DATA_W - 1)) - 1);
    localparam acc_t SAT_LO   = acc_t'(-(2 ** (DATA_W - 1)));

    function automatic acc_t widen(sample_t s);
        return acc_t'(s);
    endfunction

    // Round half toward +inf, drop the fraction, clamp to the sample range
    function automatic sample_t round_sat(acc_t a);
        acc_t q;
        q = (a + HALF_LSB) >>> FRAC_SH;
        if (q > SAT_HI)
            return SAT_HI[DATA_W-1:0];
        else if (q < SAT_LO)
            return SAT_LO[DATA_W-1:0];
        else
            return q[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/hbdec2_tapline.sv
module hbdec2_tapline
    import hbdec2_pkg::*;
#(
    parameter int DEPTH = HIST_D
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    shift_en,
    input  sample_t din,
    output sample_t taps [DEPTH]
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)
                    taps[i] <= '0;
                else if (shift_en)
                    taps[i] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)
                    taps[i] <= '0;
                else if (shift_en)
                    taps[i] <= taps[i-1];
            end
        end
    end

endmodule

// File: rtl/hbdec2_phase.sv
module hbdec2_phase
    import hbdec2_pkg::*;
#(
    parameter int WINDOW = N_TAPS
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic emit
);

    localparam logic [FILL_W-1:0] FULL = FILL_W'(WINDOW - 1);

    logic [FILL_W-1:0] fill_q;
    phase_e            phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q  <= '0;
            phase_q <= PH_EVEN;
        end else if (in_valid) begin
            if (fill_q != FULL)
                fill_q <= fill_q + 1'b1;
            phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
        end
    end

    // The incoming sample completes a window and closes an output pair
    assign emit = in_valid && (fill_q == FULL) && (phase_q == PH_EVEN);

endmodule

// File: rtl/hbdec2_csd_core.sv
module hbdec2_csd_core
    import hbdec2_pkg::*;
(
    input  sample_t newest,   // window position 0
    input  sample_t w2,
    input  sample_t w3,
    input  sample_t w4,
    input  sample_t w6,
    output acc_t    acc_o     // sum scaled by 2^FRAC_SH
);

    pairsum_t ps;

    always_comb begin
        ps.outer  = widen(newest) + widen(w6);
        ps.inner  = widen(w2) + widen(w4);
        ps.center = widen(w3);
        // 9/32 -> 2^3 + 2^0 ; 1/2 -> 2^4 ; -1/32 -> -2^0   (all scaled by 32)
        acc_o = (ps.inner <<< 3) + ps.inner + (ps.center <<< 4) - ps.outer;
    end

endmodule

// File: rtl/hbdec2_filter.sv
module hbdec2_filter
    import hbdec2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    sample_t taps [HIST_D];
    sample_t din;
    logic    emit;
    acc_t    acc;
    logic    unused_zero_taps;

    assign din = sample_t'(in_data);

    hbdec2_tapline #(.DEPTH(HIST_D)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (din),
        .taps     (taps)
    );

    hbdec2_phase #(.WINDOW(N_TAPS)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .emit     (emit)
    );

    // Window positions 1 and 5 carry zero weight and are never computed
    assign unused_zero_taps = ^{taps[0], taps[4]};

    hbdec2_csd_core u_core (
        .newest (din),
        .w2     (taps[1]),
        .w3     (taps[2]),
        .w4     (taps[3]),
        .w6     (taps[5]),
        .acc_o  (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit)
                out_data <= round_sat(acc);
        end
    end

endmodule

// File: rtl/hbdec2_checker.sv
module hbdec2_checker
    import hbdec2_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic [3:0] seen_q;   // accepted inputs since reset, saturating
    logic       odd_q;    // parity of accepted inputs

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            odd_q  <= 1'b0;
        end else if (in_valid) begin
            if (seen_q < 4'(N_TAPS))
                seen_q <= seen_q + 1'b1;
            odd_q <= ~odd_q;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);                                    // R2
    AST_PULSE_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));                               // R2
    AST_WINDOW_FILLED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen_q >= 4'(N_TAPS)));                        // R2
    AST_ODD_COUNT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> odd_q);                                         // R2
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));                            // R8

endmodule

bind hbdec2_filter hbdec2_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/hbdec2_filter_tb_top.sv
`timescale 1ns/1ps
module hbdec2_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int errors = 0;
    int checks = 0;
    int hist[$];
    int n_in = 0;
    bit exp_v = 0;
    int exp_d = 0;
    int last_out = 0;
    bit seg_hit = 0;
    bit seg_nonzero = 0;

    always #2.5 clk = ~clk;

    hbdec2_filter dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_out();
        int acc;
        int q;
        acc = -(hist[0] + hist[6]) + 9 * (hist[2] + hist[4]) + 16 * hist[3];
        q = (acc + 16) >>> 5;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    // One clock: drive at negedge, compare at the following negedge
    task automatic step(input bit v, input int x, input string tag);
        bit emit;
        in_valid = v;
        in_data  = x[15:0];
        emit = 0;
        if (v) begin
            hist.push_front(x);
            if (hist.size() > 7) void'(hist.pop_back());
            n_in++;
            emit = (n_in >= 7) && (n_in % 2 == 1);
        end
        @(posedge clk);
        @(negedge clk);
        exp_v = emit;
        if (emit) exp_d = ref_out();
        check({tag, " out_valid"}, int'(out_valid), int'(exp_v));
        check({tag, " out_data"}, int'($signed(out_data)), exp_d);
        if (out_valid) begin
            last_out = int'($signed(out_data));
            if (last_out == 1) seg_hit = 1;
            if (last_out != 0) seg_nonzero = 1;
        end
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        hist.delete();
        n_in = 0;
        exp_d = 0;
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 data in reset", int'($signed(out_data)), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 data after reset", int'($signed(out_data)), 0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        do_reset();

        // R2 / R3: impulse with idle gaps between strobes (R8)
        for (int k = 0; k < 16; k++) begin
            step(1, (k == 3) ? 1000 : 0, "R3 impulse");
            if (k % 2 == 0) step(0, 0, "R8 idle");
        end

        // R7: +1 at the centre tap of an output window
        for (int k = 0; k < 8; k++) step(1, 0, "R7 pre");
        if (n_in % 2 == 0) step(1, 0, "R7 align");
        seg_hit = 0;
        step(1, 1, "R7 plus");
        for (int k = 0; k < 8; k++) step(1, 0, "R7 tail");
        check("R7 half rounds up", int'(seg_hit), 1);

        if (n_in % 2 == 0) step(1, 0, "R7 align");
        seg_nonzero = 0;
        step(1, -1, "R7 minus");
        for (int k = 0; k < 8; k++) step(1, 0, "R7 tail");
        check("R7 minus half rounds to zero", int'(seg_nonzero), 0);

        // R4: DC gain
        for (int k = 0; k < 12; k++) step(1, 12345, "R4 dc");
        check("R4 unity dc gain", last_out, 12345);
        for (int k = 0; k < 10; k++) step(1, -7, "R4 dc neg");
        check("R4 unity dc gain negative", last_out, -7);

        // R5: Nyquist-rate alternation
        for (int k = 0; k < 12; k++) step(1, (k % 2 == 0) ? 20000 : -20000, "R5 alt");
        check("R5 nyquist null", last_out, 0);

        // R6: positive saturation
        if (n_in % 2 == 1) step(1, 0, "R6 align");
        step(1, -32768, "R6"); step(1, 0, "R6");
        step(1, 32767, "R6"); step(1, 32767, "R6"); step(1, 32767, "R6");
        step(1, 0, "R6"); step(1, -32768, "R6");
        check("R6 clamp high", last_out, 32767);

        // R6: negative saturation
        if (n_in % 2 == 1) step(1, 0, "R6 align");
        step(1, 32767, "R6"); step(1, 0, "R6");
        step(1, -32768, "R6"); step(1, -32768, "R6"); step(1, -32768, "R6");
        step(1, 0, "R6"); step(1, 32767, "R6");
        check("R6 clamp low", last_out, -32768);

        // R3 / R8: mixed stream with irregular gaps
        for (int k = 0; k < 60; k++) begin
            step(1, ((k * 7919 + 123) % 65536) - 32768, "R3 stream");
            if (k % 3 == 0) step(0, 5555, "R8 gap");
        end

        // R1 / R2: reset in mid-stream restarts the fill count
        do_reset();
        for (int k = 0; k < 12; k++) step(1, 100 * (k + 1), "R2 refill");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule